// File: doc/BRIEF.md
# Processor Sleep Entry Controller

This controller decides when a small processor core stops executing and enters a low-power state. The core reports two kinds of executed instructions as single-cycle pulses. A wait-for-interrupt request always puts the core to sleep. A wait-for-event request sleeps only if a hidden one-bit event flag is clear. If the flag is set, the request clears it and the core keeps running. The flag is set by a send-event pulse, which may come from another processor, or by any bit of an external event vector. Software has no direct access to the flag.

The controller is a three-state machine. The states are `ST_RUN`, `ST_SLP_WFI` (asleep after wait-for-interrupt) and `ST_SLP_WFE` (asleep after wait-for-event). The transitions are:
- ENTER_WFI: `ST_RUN` to `ST_SLP_WFI`.
- ENTER_WFE: `ST_RUN` to `ST_SLP_WFE`, taken only when the flag is clear and no event arrives in the same cycle.
- SKIP_WFE: `ST_RUN` back to `ST_RUN`, clearing the flag.
- WAKE_WFI: `ST_SLP_WFI` to `ST_RUN`, on an enabled pending interrupt or a debug request.
- WAKE_WFE: `ST_SLP_WFE` to `ST_RUN`, on those same causes or on any event.

The deep-sleep select input is captured at the moment of entry. It decides whether the sleep is a plain clock stop or deep sleep. The outputs drive a core clock-enable and two sleep indications that the clock and power cells use.

Top module: `core_sleep_ctrl`

## Requirements
- R1: After reset the controller is in `ST_RUN` with `core_clk_en`=1, `sleep_active`=0, `deep_active`=0, and the event flag clear. The next lone wait-for-event request therefore sleeps.
- R2: A wait-for-interrupt request in `ST_RUN` puts the controller to sleep on the next clock edge, whatever the flag and other inputs hold. The event flag is left unchanged, apart from being set by a same-cycle event.
- R3: A wait-for-event request in `ST_RUN`, with the flag clear and no event in the same cycle, enters `ST_SLP_WFE` on the next edge.
- R4: A wait-for-event request in `ST_RUN` with the flag set clears the flag, and the core stays running.
- R5: `sev_pulse`=1, or any bit of `ext_event` at 1, sets the flag while in `ST_RUN` or `ST_SLP_WFI`. When an event coincides with a wait-for-event request, the set counts as coming first: the core does not sleep and the flag ends up clear.
- R6: From either sleep state, an interrupt with matching bits set in both `irq_pend` and `irq_en`, or `dbg_req`=1, returns the controller to `ST_RUN` on the next edge. A pending interrupt whose enable bit is 0 does not wake it.
- R7: An event wakes `ST_SLP_WFE` on the next edge and is consumed, so the flag stays clear. An event does not wake `ST_SLP_WFI`.
- R8: `core_clk_en` is 0 exactly while in a sleep state, and `sleep_active` is its inverse. `deep_active` is 1 only while asleep and only if `deep_sel` was 1 on the entry cycle. Changes to `deep_sel` during sleep are ignored.
- R9: When both requests arrive in the same cycle, wait-for-interrupt wins and the flag is not cleared. Requests that arrive while asleep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt executed (pulse) |
| wfe_req | input | 1 | Wait-for-event executed (pulse) |
| sev_pulse | input | 1 | Send-event pulse |
| ext_event | input | N_EXT | External event inputs |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enable mask |
| dbg_req | input | 1 | Debug wake request |
| deep_sel | input | 1 | Deep-sleep select, sampled on entry |
| core_clk_en | output | 1 | Core clock enable |
| sleep_active | output | 1 | Core is asleep |
| deep_active | output | 1 | Core is in deep sleep |

## Verification
The event flag cannot be seen at the ports, so its state is hard to observe. The bench reads it back through behaviour. After each stimulus cycle, it wakes the core with a debug request, which does not touch the flag. It then issues a lone wait-for-event and checks whether the core sleeps. Every start condition that can be reached is built up from reset: running with the flag clear or set, asleep after wait-for-interrupt with the flag clear or set, and asleep after wait-for-event. From each one the bench applies every combination of request, event, debug and select inputs, crossed with three interrupt patterns: none, masked and enabled.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLP_WFI = 2'd1,
        ST_SLP_WFE = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int N_IRQ = 4,
    parameter int N_EXT = 2
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] ext_event,
    input  logic             sev_pulse,
    output logic             irq_wake,
    output logic             evt_any
);
    logic [N_IRQ-1:0] live_irq;

    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_irq
            assign live_irq[g] = irq_pend[g] & irq_en[g];
        end
    endgenerate

    assign irq_wake = |live_irq;
    assign evt_any  = sev_pulse | (|ext_event);
endmodule

// File: rtl/evt_latch.sv
module evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // clear has priority: a same-cycle set is treated as already consumed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (clr_i)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
    end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_req,
    input  logic       wfe_req,
    input  logic       evt_any,
    input  logic       evt_flag,
    input  logic       irq_wake,
    input  logic       dbg_req,
    input  logic       deep_sel,
    output pwr_state_t state_o,
    output logic       evt_set,
    output logic       evt_clr,
    output logic       core_clk_en,
    output logic       sleep_active,
    output logic       deep_active
);
    pwr_state_t st_q, st_d;
    logic       deep_q;
    logic       entering;

    // next-state and latch control
    always_comb begin
        st_d    = st_q;
        evt_set = 1'b0;
        evt_clr = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                evt_set = evt_any;
                if (wfi_req) begin
                    st_d = ST_SLP_WFI;              // ENTER_WFI
                end else if (wfe_req) begin
                    if (evt_flag || evt_any)
                        evt_clr = 1'b1;             // SKIP_WFE
                    else
                        st_d = ST_SLP_WFE;          // ENTER_WFE
                end
            end
            ST_SLP_WFI: begin
                evt_set = evt_any;
                if (irq_wake || dbg_req)
                    st_d = ST_RUN;                  // WAKE_WFI
            end
            ST_SLP_WFE: begin
                if (irq_wake || dbg_req || evt_any)
                    st_d = ST_RUN;                  // WAKE_WFE, event consumed
            end
            default: st_d = ST_RUN;
        endcase
    end

    assign entering = (st_q == ST_RUN) && (st_d != ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            deep_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (entering)
                deep_q <= deep_sel;
        end
    end

    // outputs
    always_comb begin
        core_clk_en  = 1'b1;
        sleep_active = 1'b0;
        deep_active  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                core_clk_en = 1'b1;
            end
            ST_SLP_WFI, ST_SLP_WFE: begin
                core_clk_en  = 1'b0;
                sleep_active = 1'b1;
                deep_active  = deep_q;
            end
            default: begin
                core_clk_en = 1'b1;
            end
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             sev_pulse,
    input  logic [N_EXT-1:0] ext_event,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             dbg_req,
    input  logic             deep_sel,
    output logic             core_clk_en,
    output logic             sleep_active,
    output logic             deep_active
);
    logic       irq_wake;
    logic       evt_any;
    logic       evt_flag;
    logic       evt_set;
    logic       evt_clr;
    pwr_state_t state;

    wake_detect #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_wake (
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .ext_event (ext_event),
        .sev_pulse (sev_pulse),
        .irq_wake  (irq_wake),
        .evt_any   (evt_any)
    );

    evt_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .flag_o (evt_flag)
    );

    sleep_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wfi_req      (wfi_req),
        .wfe_req      (wfe_req),
        .evt_any      (evt_any),
        .evt_flag     (evt_flag),
        .irq_wake     (irq_wake),
        .dbg_req      (dbg_req),
        .deep_sel     (deep_sel),
        .state_o      (state),
        .evt_set      (evt_set),
        .evt_clr      (evt_clr),
        .core_clk_en  (core_clk_en),
        .sleep_active (sleep_active),
        .deep_active  (deep_active)
    );
endmodule

// File: rtl/core_sleep_ctrl_chk.sv
module core_sleep_ctrl_chk
    import sleep_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int N_EXT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wfi_req,
    input logic             wfe_req,
    input logic             sev_pulse,
    input logic [N_EXT-1:0] ext_event,
    input logic [N_IRQ-1:0] irq_pend,
    input logic [N_IRQ-1:0] irq_en,
    input logic             dbg_req,
    input logic             core_clk_en,
    input logic             sleep_active,
    input logic             deep_active,
    input logic             evt_flag,
    input pwr_state_t       state
);
    logic ev_in, irq_in;
    assign ev_in  = sev_pulse | (|ext_event);
    assign irq_in = |(irq_pend & irq_en);

    assert_wfi_sleeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && wfi_req) |=> sleep_active);

    assert_wfe_sleeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && wfe_req && !wfi_req && !evt_flag && !ev_in) |=> sleep_active);

    assert_wfe_skips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && wfe_req && !wfi_req && (evt_flag || ev_in)) |=> (core_clk_en && !evt_flag));

    assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && (irq_in || dbg_req)) |=> core_clk_en);

    assert_wfe_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLP_WFE) |-> !evt_flag);

    assert_deep_in_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deep_active |-> sleep_active);

    assert_deep_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && $past(sleep_active)) |-> (deep_active == $past(deep_active)));
endmodule

bind core_sleep_ctrl core_sleep_ctrl_chk #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wfi_req      (wfi_req),
    .wfe_req      (wfe_req),
    .sev_pulse    (sev_pulse),
    .ext_event    (ext_event),
    .irq_pend     (irq_pend),
    .irq_en       (irq_en),
    .dbg_req      (dbg_req),
    .core_clk_en  (core_clk_en),
    .sleep_active (sleep_active),
    .deep_active  (deep_active),
    .evt_flag     (evt_flag),
    .state        (state)
);

// File: tb/core_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module core_sleep_ctrl_tb;
    localparam int N_IRQ = 4;
    localparam int N_EXT = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wfi_req = 1'b0, wfe_req = 1'b0, sev_pulse = 1'b0;
    logic [N_EXT-1:0] ext_event = '0;
    logic [N_IRQ-1:0] irq_pend = '0, irq_en = '0;
    logic             dbg_req = 1'b0, deep_sel = 1'b0;
    logic             core_clk_en, sleep_active, deep_active;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    core_sleep_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .sev_pulse(sev_pulse), .ext_event(ext_event), .irq_pend(irq_pend),
        .irq_en(irq_en), .dbg_req(dbg_req), .deep_sel(deep_sel),
        .core_clk_en(core_clk_en), .sleep_active(sleep_active),
        .deep_active(deep_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        wfi_req = 0; wfe_req = 0; sev_pulse = 0; ext_event = '0;
        irq_pend = '0; irq_en = '0; dbg_req = 0; deep_sel = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // drive for one edge, return at the following falling edge with inputs cleared
    task automatic pulse(input bit wfi, input bit wfe, input bit sev, input logic [N_EXT-1:0] ext,
                         input logic [N_IRQ-1:0] pend, input logic [N_IRQ-1:0] en,
                         input bit dbg, input bit deep);
        @(negedge clk);
        wfi_req = wfi; wfe_req = wfe; sev_pulse = sev; ext_event = ext;
        irq_pend = pend; irq_en = en; dbg_req = dbg; deep_sel = deep;
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(core_clk_en == 1, "R1 clk_en", core_clk_en, 1);
        chk(sleep_active == 0, "R1 sleep", sleep_active, 0);
        chk(deep_active == 0, "R1 deep", deep_active, 0);
        pulse(0, 1, 0, '0, '0, '0, 0, 0);
        chk(sleep_active == 1, "R1 flag clear after reset", sleep_active, 1);

        // cfg: 0 run/flag0, 1 run/flag1, 2 wfi/flag0, 3 wfi/flag1, 4 wfe/flag0
        for (int cfg = 0; cfg < 5; cfg++) begin
            for (int de = 0; de < 2; de++) begin
                for (int v = 0; v < 64; v++) begin
                    for (int im = 0; im < 3; im++) begin
                        int s, l, ns, nl, nd;
                        bit wfi, wfe, sev, dbg, dsel, ev, irq;
                        logic [N_EXT-1:0] ext;
                        logic [N_IRQ-1:0] pend, en;
                        string tag;

                        l = (cfg == 1 || cfg == 3) ? 1 : 0;
                        s = (cfg < 2) ? 0 : (cfg < 4 ? 1 : 2);
                        do_reset();
                        if (l == 1) pulse(0, 0, 1, '0, '0, '0, 0, 0);
                        if (s == 1) pulse(1, 0, 0, '0, '0, '0, 0, de[0]);
                        if (s == 2) pulse(0, 1, 0, '0, '0, '0, 0, de[0]);
                        if (s != 0)
                            chk(deep_active == (de == 1), "R8 deep at entry", deep_active, de);

                        wfi  = v[0]; wfe = v[1]; sev = v[2];
                        ext  = v[3] ? (de == 1 ? 2'b10 : 2'b01) : 2'b00;
                        dbg  = v[4]; dsel = v[5];
                        pend = (im == 0) ? 4'b0000 : 4'b0100;
                        en   = (im == 2) ? 4'b0110 : 4'b1011;
                        ev   = sev | v[3];
                        irq  = (im == 2);

                        // expected result from the requirements
                        ns = s; nl = l; nd = (s != 0) ? de : 0;
                        if (s == 0) begin
                            if (wfi) begin ns = 1; nl = l | ev; tag = "R2/R9"; end
                            else if (wfe) begin
                                if (l == 1 || ev) begin nl = 0; tag = ev ? "R5" : "R4"; end
                                else begin ns = 2; nl = 0; tag = "R3"; end
                            end else begin nl = l | ev; tag = "R5"; end
                            if (ns != 0) nd = dsel;
                        end else if (s == 1) begin
                            nl = l | ev;
                            if (irq || dbg) ns = 0;
                            tag = "R6";
                        end else begin
                            nl = 0;
                            if (irq || dbg || ev) ns = 0;
                            tag = "R7";
                        end

                        pulse(wfi, wfe, sev, ext, pend, en, dbg, dsel);
                        chk(sleep_active == (ns != 0), tag, sleep_active, ns != 0);
                        chk(core_clk_en == (ns == 0), "R8 clk_en", core_clk_en, ns == 0);
                        chk(deep_active == (ns != 0 && nd == 1), "R8 deep",
                            deep_active, (ns != 0 && nd == 1));

                        // expose the hidden flag: debug wake, then a lone wait-for-event
                        if (ns != 0) pulse(0, 0, 0, '0, '0, '0, 1, 0);
                        pulse(0, 1, 0, '0, '0, '0, 0, 0);
                        chk(sleep_active == (nl == 0), "R5 flag probe", sleep_active, nl == 0);
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule